// File: doc/BRIEF.md
# Ones' Complement End-Around Carry Adder

This block adds two N-bit ones' complement operands in a single clock. In ones' complement arithmetic the carry that leaves the top bit has to be fed back into the bottom bit. Done with a real wire, that feedback forms a combinational loop. When the operands cancel, that loop has no unique settled value. Here the loop is cut at the wrap point. A first ripple pass receives a preconditioned carry and produces the wrap carry. A second pass folds that wrap carry back into the lowest bit. The whole path is acyclic, and a cancelling sum always lands on a defined encoding of zero.

Two zero policies are offered, chosen per addition by `mode_i`. With policy 0 the first pass starts from a carry of zero. A cancelling sum then always yields negative zero (all ones). With policy 1 the first pass starts from the wrap carry remembered from the last accepted addition. A cancelling sum then yields positive zero (all zeros) if that remembered carry was 1, and negative zero if it was 0. The remembered carry is held by a two-state machine. State `WRAP_CLR` means the last wrap carry was 0, and `WRAP_SET` means it was 1. On every accepted addition the machine goes to `WRAP_SET` if the new wrap carry is 1 and to `WRAP_CLR` if it is 0. Otherwise it stays where it is. Reset places it in `WRAP_CLR`.

Results are registered. `valid_o` marks the cycle after an accepted addition, and `neg_zero_o` flags a result of all ones.

Top module: `oc_endaround_adder`

## Requirements
- R1: After reset `valid_o`, `sum_o` and `neg_zero_o` are all 0, and the remembered wrap carry is 0 (state `WRAP_CLR`).
- R2: When the integer sum a+b is not 2^N-1, `sum_o` equals a+b if a+b < 2^N, and a+b-2^N+1 otherwise. This holds under either policy.
- R3: With `mode_i`=0, operands whose integer sum is exactly 2^N-1 give `sum_o` all ones (negative zero).
- R4: With `mode_i`=1, operands whose integer sum is exactly 2^N-1 give all zeros if the remembered wrap carry is 1, and all ones if it is 0.
- R5: Each accepted addition updates the remembered wrap carry to that addition's wrap carry: 1 exactly when a+b ≥ 2^N, or when a+b = 2^N-1 under policy 1 with a remembered carry of 1. Cycles with `valid_i`=0 leave it unchanged.
- R6: `valid_o` equals `valid_i` of the previous clock cycle.
- R7: While `valid_i` is 0, `sum_o` and `neg_zero_o` keep their values.
- R8: `neg_zero_o` is 1 exactly when `sum_o` is all ones.
- R9: The result of an addition accepted at one rising edge appears on `sum_o` right after that edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Zero policy: 0 = start from zero carry, 1 = start from remembered wrap carry |
| valid_i | input | 1 | Operands present this cycle |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sum_o | output | N | Registered ones' complement sum |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| neg_zero_o | output | 1 | Registered sum is all ones |

## Verification
The embedded properties check the following on every clock:
- The second pass reproduces the wrap carry of the first, so the broken loop has settled.
- The valid strobe tracks `valid_i` one cycle later.
- Outputs hold while idle.
- The negative-zero flag agrees with the sum.
- A cancelling sum goes to the correct zero encoding under each policy.

Only the bench scenarios can show the dependence that spans many cycles. These scenarios first arm the remembered carry through a carrying addition and then insert idle cycles with garbage operands. They then check that the later cancelling sum under policy 1 still reflects the carry that was armed. The bench also compares full arithmetic results against an integer model over a long pseudo-random operand stream.

// File: rtl/oc_add_pkg.sv
package oc_add_pkg;

    typedef enum logic {
        WRAP_CLR = 1'b0,
        WRAP_SET = 1'b1
    } wrap_state_t;

    typedef enum logic {
        POLICY_ZERO_CARRY = 1'b0,
        POLICY_HELD_CARRY = 1'b1
    } zero_policy_t;

endpackage

// File: rtl/oc_ripple_pass.sv
// One ripple pass over W bits with an explicit carry input.
module oc_ripple_pass #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] s_o,
    output logic         cout_o
);

    always_comb begin
        logic c;
        c = cin_i;
        for (int k = 0; k < W; k++) begin
            s_o[k] = x_i[k] ^ y_i[k] ^ c;
            c      = (x_i[k] & y_i[k]) | (c & (x_i[k] ^ y_i[k]));
        end
        cout_o = c;
    end

endmodule

// File: rtl/oc_wrap_fsm.sv
// Remembers the wrap carry of the last accepted addition.
module oc_wrap_fsm
    import oc_add_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic wrap_i,
    output logic held_o
);

    wrap_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WRAP_CLR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WRAP_CLR: if (accept_i && wrap_i)  state_d = WRAP_SET;
            WRAP_SET: if (accept_i && !wrap_i) state_d = WRAP_CLR;
            default:  state_d = WRAP_CLR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            WRAP_SET: held_o = 1'b1;
            default:  held_o = 1'b0;
        endcase
    end

    // R5: idle cycles leave the remembered carry untouched
    assert_carry_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(state_q));

endmodule

// File: rtl/oc_out_stage.sv
// Result registers; load only on accepted additions.
module oc_out_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept_i,
    input  logic [W-1:0] sum_i,
    output logic [W-1:0] sum_o,
    output logic         valid_o,
    output logic         neg_zero_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o      <= '0;
            neg_zero_o <= 1'b0;
            valid_o    <= 1'b0;
        end else begin
            valid_o <= accept_i;
            if (accept_i) begin
                sum_o      <= sum_i;
                neg_zero_o <= (sum_i == ALL_ONES);
            end
        end
    end

endmodule

// File: rtl/oc_endaround_adder.sv
module oc_endaround_adder
    import oc_add_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         valid_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         valid_o,
    output logic         neg_zero_o
);

    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

    zero_policy_t policy;
    logic         held_c;
    logic         pre_c;
    logic         wrap_c;
    logic         fold_cout;
    logic [N-1:0] pre_sum;
    logic [N-1:0] fold_sum;

    assign policy = zero_policy_t'(mode_i);

    always_comb begin
        unique case (policy)
            POLICY_HELD_CARRY: pre_c = held_c;
            default:           pre_c = 1'b0;
        endcase
    end

    // First pass: preconditioned carry in, produces the wrap carry.
    oc_ripple_pass #(.W(N)) u_pre (
        .x_i(a_i), .y_i(b_i), .cin_i(pre_c),
        .s_o(pre_sum), .cout_o(wrap_c)
    );

    // Second pass: wrap carry folded back into the LSB.
    oc_ripple_pass #(.W(N)) u_fold (
        .x_i(a_i), .y_i(b_i), .cin_i(wrap_c),
        .s_o(fold_sum), .cout_o(fold_cout)
    );

    oc_wrap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .accept_i(valid_i),
        .wrap_i(wrap_c), .held_o(held_c)
    );

    oc_out_stage #(.W(N)) u_out (
        .clk(clk), .rst_n(rst_n), .accept_i(valid_i), .sum_i(fold_sum),
        .sum_o(sum_o), .valid_o(valid_o), .neg_zero_o(neg_zero_o)
    );

    // R2: the folded pass reproduces the wrap carry, so the cut loop is settled
    assert_loop_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (fold_cout == wrap_c) || (pre_sum == ALL_ONES && !pre_c));

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    assert_valid_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(sum_o) && $stable(neg_zero_o));

    assert_negzero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        neg_zero_o == (sum_o == ALL_ONES));

    assert_zero_policy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mode_i && a_i == ~b_i) |=> neg_zero_o);

    assert_held_pos_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i && held_c && a_i == ~b_i) |=> (sum_o == '0));

    assert_held_neg_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i && !held_c && a_i == ~b_i) |=> neg_zero_o);

endmodule

// File: tb/oc_endaround_adder_tb.sv
module oc_endaround_adder_tb;

    localparam int N = 16;
    localparam longint MOD  = 64'd1 << N;
    localparam longint MASK = MOD - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_i = 1'b0;
    logic         valid_i = 1'b0;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] b_i = '0;
    logic [N-1:0] sum_o;
    logic         valid_o;
    logic         neg_zero_o;

    int vectors = 0;
    int misses  = 0;

    longint m_sum   = 0;
    bit     m_valid = 0;
    bit     m_carry = 0;

    always #4 clk = ~clk;

    oc_endaround_adder #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .valid_i(valid_i),
        .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .valid_o(valid_o),
        .neg_zero_o(neg_zero_o)
    );

    task automatic compare(input string tag);
        bit nz;
        nz = (m_sum == MASK);
        vectors++;
        if (valid_o !== m_valid) begin
            misses++;
            $display("FAIL %s valid_o actual=%0b expected=%0b", tag, valid_o, m_valid);
        end
        if (longint'(sum_o) !== m_sum) begin
            misses++;
            $display("FAIL %s sum_o actual=%h expected=%h", tag, sum_o, m_sum[N-1:0]);
        end
        if (neg_zero_o !== nz) begin
            misses++;
            $display("FAIL R8 (%s) neg_zero_o actual=%0b expected=%0b", tag, neg_zero_o, nz);
        end
    endtask

    // Behavioural reference: integer arithmetic, zero cases handled by rule.
    task automatic step(input bit md, input bit v, input longint a, input longint b,
                        input string tag);
        longint t;
        mode_i  = md;
        valid_i = v;
        a_i     = a[N-1:0];
        b_i     = b[N-1:0];
        @(posedge clk);
        m_valid = v;
        if (v) begin
            t = a + b;
            if (t == MASK) begin
                if (md && m_carry) m_sum = 0;
                else begin
                    m_sum = MASK;
                    m_carry = 0;
                end
            end else if (t >= MOD) begin
                m_sum = t - MOD + 1;
                m_carry = 1;
            end else begin
                m_sum = t;
                m_carry = 0;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 150000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        longint lf;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2/R9 directed, both policies
        step(0, 1, 16'h0003, 16'h0004, "R2 small");
        step(1, 1, 16'h8000, 16'h8001, "R2 wrap carry");
        step(0, 1, 16'hFFFF, 16'hFFFF, "R2 both neg zero");
        step(0, 1, 16'h0000, 16'h0000, "R3 pos zero operands");
        // R3: cancelling sum under zero-carry policy
        step(0, 1, 16'h1234, 16'hEDCB, "R3 cancel");
        // R4: arm carry, then cancel under held policy
        step(1, 1, 16'hC000, 16'h4000, "R5 arm carry");
        step(1, 1, 16'h00FF, 16'hFF00, "R4 held carry one");
        step(1, 1, 16'h5555, 16'hAAAA, "R4 held carry kept");
        // R6/R7/R5: idle cycles with garbage operands must not disturb anything
        step(0, 0, 16'h7777, 16'h1111, "R7 idle");
        step(1, 0, 16'hFFFF, 16'h0001, "R7 idle");
        step(1, 1, 16'h0F0F, 16'hF0F0, "R5 carry survives idle");
        step(1, 1, 16'h0001, 16'h0002, "R5 clear carry");
        step(0, 0, 16'h8000, 16'h8000, "R6 idle");
        step(1, 1, 16'h3C3C, 16'hC3C3, "R4 held carry zero");
        step(0, 1, 16'h8000, 16'h8000, "R5 arm via policy 0");
        step(1, 1, 16'hFFFF, 16'h0000, "R4 held after policy 0 arm");

        lf = 64'h1ACE;
        for (int i = 0; i < 400; i++) begin
            longint x, y;
            lf = (lf * 64'd6364136223846793005 + 64'd1442695040888963407);
            x = (lf >>> 20) & MASK;
            y = (lf >>> 40) & MASK;
            if (i % 7 == 3) y = MASK - x;
            step(bit'(i % 3 == 0), bit'(i % 5 != 4), x, y, "R2 stream");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule